// File: doc/BRIEF.md
# Pulse-and-Verify Byte Memory Programmer

This controller writes a byte image into an erasable, byte-wide programmable memory. It walks the device addresses in ascending order. For each byte it reads the target value from an image port. A target that is all ones is already the erased value, so the controller moves straight to the next address. Any other target gets a program pulse of fixed width, followed by a read-back of the same address. Pulses repeat until the read-back equals the target or a pulse limit is reached. The pulsing phase runs with both the programming supply and the elevated core supply requested.

After the last address, both supply requests drop to their nominal read levels and the controller waits a settle time. It then reads every address again as a normal read and compares each byte with the image. It finishes with `done_o` set, or with `fail_o` set and the offending address held in `fail_addr_o`. Pulse width, read time, settle time and pulse limit are parameters counted in clock cycles. The device data bus is split into an output, a drive enable and an input, so that the tristate buffer can sit at the pad.

Top module: `eprog_top`

## Requirements
- R1: While reset is active, and after it until a start, the device is deselected: `dev_ce_no`=1, `dev_oe_no`=1, `dev_drive_o`=0. In the same period `vpp_hi_o`, `vcc_hi_o`, `busy_o`, `done_o` and `fail_o` are 0, and `dev_addr_o` and `fail_addr_o` are 0.
- R2: A start sampled while idle, done or failed raises `vpp_hi_o`=1 and `vcc_hi_o`=1 and `busy_o`=1. It then holds the device deselected at address 0 for exactly SETTLE_CYC cycles before the first address is taken.
- R3: A program pulse drives `dev_ce_no`=0, `dev_oe_no`=1, `dev_drive_o`=1 and `dev_data_o`=target for exactly PULSE_CYC cycles, with both supply requests high.
- R4: Every pulse is followed by a verify read of READ_CYC cycles with `dev_ce_no`=1, `dev_oe_no`=0 and `dev_drive_o`=0. `dev_data_i` is sampled in the last cycle, and a match ends work on that address.
- R5: A verify mismatch is followed by another pulse on the same address, as long as fewer than MAX_PULSES pulses have been applied there. A byte that first matches on pulse MAX_PULSES still passes.
- R6: Each address spends one cycle deselected while its target is fetched. A target of all ones receives no pulse, and the controller moves on after that one cycle.
- R7: A mismatch after the MAX_PULSES-th pulse ends the run. `fail_o`=1, `fail_addr_o` holds that address, `busy_o`=0, both supply requests are 0 and the device is deselected, until the next start.
- R8: After the last address, both supply requests go to 0, and the device is deselected at address 0 for SETTLE_CYC cycles. Every address is then read in ascending order for READ_CYC cycles each, with `dev_ce_no`=0 and `dev_oe_no`=0.
- R9: A final-read byte that differs from the image ends the run as in R7, with that address in `fail_addr_o`.
- R10: When every final read matches, `done_o`=1, `busy_o`=0, both supply requests are 0, the device is deselected and `dev_addr_o` stays at the last address.
- R11: A start while `busy_o`=1 has no effect. A start from done or failed clears `done_o`, `fail_o` and `fail_addr_o` in the cycle after it is sampled.
- R12: Programming visits addresses 0 to 2^AW-1 in ascending order, one at a time, and `img_addr_o` always equals `dev_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a programming run |
| img_addr_o | output | AW | Image read address |
| img_data_i | input | DW | Image byte at `img_addr_o`, same cycle |
| dev_addr_o | output | AW | Device address pins |
| dev_data_o | output | DW | Data driven onto the device during a pulse |
| dev_drive_o | output | 1 | Enables the data pad drivers |
| dev_data_i | input | DW | Data read from the device pins |
| dev_ce_no | output | 1 | Device chip enable, active low, doubles as program strobe |
| dev_oe_no | output | 1 | Device output enable, active low |
| vpp_hi_o | output | 1 | Request programming voltage on the program supply |
| vcc_hi_o | output | 1 | Request elevated core supply (0 selects the nominal verify level) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished with every byte matching |
| fail_o | output | 1 | Run stopped on a byte that would not verify |
| fail_addr_o | output | AW | Address that caused `fail_o` |

## Verification
The bench models a device whose bytes need different numbers of pulses, including one that matches only on the final allowed pulse. A controller with an off-by-one limit would fail there, or would apply one pulse too many at a stuck byte. A byte that never programs must stop the run at its own address. A controller that moved on anyway would report success, or would latch the wrong address. One byte reads correctly at the programming supply but loses a bit at the nominal one. Only a true second pass at the nominal supply flags it, so a design that skipped that pass or kept the supply high would end in `done_o`. All-ones targets, a start raised mid-run, and the last address are exercised as well. A pulse on a skipped byte, a restart, or a wrap before the final address would each break the cycle trace.

// File: rtl/eprog_pkg.sv
package eprog_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_SET_P = 4'd1,
    ST_LOAD  = 4'd2,
    ST_PULSE = 4'd3,
    ST_VRFY  = 4'd4,
    ST_SET_V = 4'd5,
    ST_FREAD = 4'd6,
    ST_DONE  = 4'd7,
    ST_FAIL  = 4'd8
  } eprog_st_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic drive;
    logic vpp_hi;
    logic vcc_hi;
    logic busy;
    logic done;
    logic fail;
  } eprog_pins_t;
endpackage

// File: rtl/eprog_timer.sv
module eprog_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/eprog_seq.sv
module eprog_seq
  import eprog_pkg::*;
#(
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int PULSE_CYC  = 5000,
  parameter int READ_CYC   = 4,
  parameter int SETTLE_CYC = 500,
  parameter int MAX_PULSES = 25,
  parameter int CW         = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] img_data_i,
  input  logic [DW-1:0] dev_data_i,
  input  logic          t_last_i,
  output eprog_st_e     st_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] tgt_o,
  output logic [AW-1:0] fail_addr_o,
  output logic          t_load_o,
  output logic [CW-1:0] t_val_o
);
  localparam int PCW = $clog2(MAX_PULSES + 1);
  localparam logic [DW-1:0] ERASED = {DW{1'b1}};

  eprog_st_e      st_q, st_d;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  tgt_q;
  logic [PCW-1:0] pcnt_q;
  logic [AW-1:0]  faddr_q;
  logic           adv, zero_addr, at_last, idle_like;

  assign at_last   = (addr_q == {AW{1'b1}});
  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_FAIL);

  always_comb begin
    st_d      = st_q;
    adv       = 1'b0;
    zero_addr = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: if (start_i) st_d = ST_SET_P;
      ST_SET_P: if (t_last_i) st_d = ST_LOAD;
      ST_LOAD: begin
        if (img_data_i == ERASED) begin
          if (at_last) begin st_d = ST_SET_V; zero_addr = 1'b1; end
          else adv = 1'b1;
        end else begin
          st_d = ST_PULSE;
        end
      end
      ST_PULSE: if (t_last_i) st_d = ST_VRFY;
      ST_VRFY: if (t_last_i) begin
        if (dev_data_i == tgt_q) begin
          if (at_last) begin st_d = ST_SET_V; zero_addr = 1'b1; end
          else begin st_d = ST_LOAD; adv = 1'b1; end
        end else if (pcnt_q == PCW'(MAX_PULSES)) begin
          st_d = ST_FAIL;
        end else begin
          st_d = ST_PULSE;
        end
      end
      ST_SET_V: if (t_last_i) st_d = ST_FREAD;
      ST_FREAD: if (t_last_i) begin
        if (dev_data_i != img_data_i) st_d = ST_FAIL;
        else if (at_last)             st_d = ST_DONE;
        else                          adv  = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_SET_P, ST_SET_V: t_val_o = CW'(SETTLE_CYC - 1);
      ST_PULSE:           t_val_o = CW'(PULSE_CYC - 1);
      ST_VRFY, ST_FREAD:  t_val_o = CW'(READ_CYC - 1);
      default:            t_val_o = '0;
    endcase
  end
  assign t_load_o = (st_d != st_q) || adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      tgt_q   <= '0;
      pcnt_q  <= '0;
      faddr_q <= '0;
    end else begin
      st_q <= st_d;
      if (idle_like && start_i) begin
        addr_q  <= '0;
        faddr_q <= '0;
      end else if (zero_addr) begin
        addr_q <= '0;
      end else if (adv) begin
        addr_q <= addr_q + 1'b1;
      end
      if (st_q == ST_LOAD) begin
        tgt_q  <= img_data_i;
        pcnt_q <= '0;
      end else if (st_q == ST_PULSE && t_last_i) begin
        pcnt_q <= pcnt_q + 1'b1;
      end
      if (st_d == ST_FAIL && st_q != ST_FAIL) faddr_q <= addr_q;
    end
  end

  assign st_o        = st_q;
  assign addr_o      = addr_q;
  assign tgt_o       = tgt_q;
  assign fail_addr_o = faddr_q;
endmodule

// File: rtl/eprog_pins.sv
module eprog_pins
  import eprog_pkg::*;
(
  input  eprog_st_e   st_i,
  output eprog_pins_t pins_o
);
  always_comb begin
    pins_o = '{ce_n: 1'b1, oe_n: 1'b1, drive: 1'b0, vpp_hi: 1'b0,
               vcc_hi: 1'b0, busy: 1'b1, done: 1'b0, fail: 1'b0};
    unique case (st_i)
      ST_IDLE:  pins_o.busy = 1'b0;
      ST_DONE:  begin pins_o.busy = 1'b0; pins_o.done = 1'b1; end
      ST_FAIL:  begin pins_o.busy = 1'b0; pins_o.fail = 1'b1; end
      ST_SET_P, ST_LOAD: begin pins_o.vpp_hi = 1'b1; pins_o.vcc_hi = 1'b1; end
      ST_PULSE: begin
        pins_o.vpp_hi = 1'b1; pins_o.vcc_hi = 1'b1;
        pins_o.ce_n   = 1'b0; pins_o.drive  = 1'b1;
      end
      ST_VRFY: begin
        pins_o.vpp_hi = 1'b1; pins_o.vcc_hi = 1'b1;
        pins_o.oe_n   = 1'b0;
      end
      ST_SET_V: ;
      ST_FREAD: begin pins_o.ce_n = 1'b0; pins_o.oe_n = 1'b0; end
      default:  pins_o.busy = 1'b0;
    endcase
  end
endmodule

// File: rtl/eprog_top.sv
module eprog_top
  import eprog_pkg::*;
#(
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int PULSE_CYC  = 5000,
  parameter int READ_CYC   = 4,
  parameter int SETTLE_CYC = 500,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [AW-1:0] img_addr_o,
  input  logic [DW-1:0] img_data_i,
  output logic [AW-1:0] dev_addr_o,
  output logic [DW-1:0] dev_data_o,
  output logic          dev_drive_o,
  input  logic [DW-1:0] dev_data_i,
  output logic          dev_ce_no,
  output logic          dev_oe_no,
  output logic          vpp_hi_o,
  output logic          vcc_hi_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);
  localparam int TMAX1 = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int TMAX  = (TMAX1 > READ_CYC) ? TMAX1 : READ_CYC;
  localparam int CW    = $clog2(TMAX + 1);

  eprog_st_e     st;
  eprog_pins_t   pins;
  logic [AW-1:0] addr;
  logic [DW-1:0] tgt;
  logic          t_load, t_last;
  logic [CW-1:0] t_val;

  eprog_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .last_o (t_last)
  );

  eprog_seq #(
    .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .READ_CYC(READ_CYC),
    .SETTLE_CYC(SETTLE_CYC), .MAX_PULSES(MAX_PULSES), .CW(CW)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .img_data_i  (img_data_i),
    .dev_data_i  (dev_data_i),
    .t_last_i    (t_last),
    .st_o        (st),
    .addr_o      (addr),
    .tgt_o       (tgt),
    .fail_addr_o (fail_addr_o),
    .t_load_o    (t_load),
    .t_val_o     (t_val)
  );

  eprog_pins u_pins (
    .st_i   (st),
    .pins_o (pins)
  );

  assign img_addr_o  = addr;
  assign dev_addr_o  = addr;
  assign dev_data_o  = tgt;
  assign dev_drive_o = pins.drive;
  assign dev_ce_no   = pins.ce_n;
  assign dev_oe_no   = pins.oe_n;
  assign vpp_hi_o    = pins.vpp_hi;
  assign vcc_hi_o    = pins.vcc_hi;
  assign busy_o      = pins.busy;
  assign done_o      = pins.done;
  assign fail_o      = pins.fail;
endmodule

// File: rtl/eprog_chk.sv
module eprog_chk #(
  parameter int AW = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] img_addr_o,
  input logic [AW-1:0] dev_addr_o,
  input logic          dev_drive_o,
  input logic          dev_ce_no,
  input logic          dev_oe_no,
  input logic          vpp_hi_o,
  input logic          vcc_hi_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [AW-1:0] fail_addr_o
);
  // R3
  drive_in_prog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_drive_o |-> (!dev_ce_no && dev_oe_no && vpp_hi_o && vcc_hi_o));

  // R4
  no_read_at_vpp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpp_hi_o |-> (dev_ce_no || dev_oe_no));

  // R7
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> (fail_o && $stable(fail_addr_o)));

  // R10
  done_fail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  // R8
  idle_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!vpp_hi_o && !vcc_hi_o && dev_ce_no && dev_oe_no));

  // R12
  addr_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    img_addr_o == dev_addr_o);

  // R12
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_addr_o != $past(dev_addr_o)) |->
      ((dev_addr_o == $past(dev_addr_o) + 1'b1) || (dev_addr_o == '0)));
endmodule

bind eprog_top eprog_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .img_addr_o  (img_addr_o),
  .dev_addr_o  (dev_addr_o),
  .dev_drive_o (dev_drive_o),
  .dev_ce_no   (dev_ce_no),
  .dev_oe_no   (dev_oe_no),
  .vpp_hi_o    (vpp_hi_o),
  .vcc_hi_o    (vcc_hi_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .fail_addr_o (fail_addr_o)
);

// File: tb/eprog_top_tb.sv
`timescale 1ns/1ps
module eprog_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int PULSE = 3;
  localparam int READ  = 2;
  localparam int SETTLE = 4;
  localparam int MAXP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] img_addr, dev_addr, fail_addr;
  logic [DW-1:0] img_data, dev_wdata, dev_rdata;
  logic dev_drive, ce_n, oe_n, vpp_hi, vcc_hi, busy, done, fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprog_top #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE), .READ_CYC(READ),
              .SETTLE_CYC(SETTLE), .MAX_PULSES(MAXP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .img_addr_o(img_addr), .img_data_i(img_data),
    .dev_addr_o(dev_addr), .dev_data_o(dev_wdata), .dev_drive_o(dev_drive),
    .dev_data_i(dev_rdata), .dev_ce_no(ce_n), .dev_oe_no(oe_n),
    .vpp_hi_o(vpp_hi), .vcc_hi_o(vcc_hi), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fail_addr_o(fail_addr)
  );

  // image and device model
  logic [DW-1:0] img [N];
  logic [DW-1:0] mem [N];
  int  need [N];
  bit  bad [N];
  bit  leaky [N];
  int  pcnt [N];
  bit  in_pulse = 0;
  int  pulse_addr = 0;

  always_comb img_data = img[img_addr];
  always_comb begin
    if (oe_n) dev_rdata = 8'hFF;
    else if (leaky[dev_addr] && !vpp_hi) dev_rdata = mem[dev_addr] | 8'h01;
    else dev_rdata = mem[dev_addr];
  end

  always @(negedge clk) begin
    if (dev_drive) begin
      in_pulse = 1;
      pulse_addr = int'(dev_addr);
    end else if (in_pulse) begin
      in_pulse = 0;
      pcnt[pulse_addr] = pcnt[pulse_addr] + 1;
      if (!bad[pulse_addr] && pcnt[pulse_addr] >= need[pulse_addr])
        mem[pulse_addr] = img[pulse_addr];
    end
  end

  // reference expectations
  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  bit e_ce = 1, e_oe = 1, e_drv = 0, e_vpp = 0, e_vcc = 0, e_busy = 0, e_done = 0, e_fail = 0;
  logic [AW-1:0] e_addr = '0, e_faddr = '0;
  logic [DW-1:0] e_data = '0;
  string e_tag = "R1";

  always @(negedge clk) begin
    if (chk_on) begin
      checks++;
      if ({ce_n, oe_n, dev_drive, vpp_hi, vcc_hi, busy, done, fail} !==
          {e_ce, e_oe, e_drv, e_vpp, e_vcc, e_busy, e_done, e_fail} ||
          dev_addr !== e_addr || fail_addr !== e_faddr ||
          (e_drv && dev_wdata !== e_data)) begin
        errors++;
        $display("FAIL %s t=%0t: ce/oe/drv/vpp/vcc/busy/done/fail=%b%b%b%b%b%b%b%b addr=%0d faddr=%0d data=%h exp %b%b%b%b%b%b%b%b addr=%0d faddr=%0d data=%h",
                 e_tag, $time, ce_n, oe_n, dev_drive, vpp_hi, vcc_hi, busy, done, fail,
                 dev_addr, fail_addr, dev_wdata, e_ce, e_oe, e_drv, e_vpp, e_vcc,
                 e_busy, e_done, e_fail, e_addr, e_faddr, e_data);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_exp(input bit ce, oe, drv, vpp, vcc, bsy, dn, fl,
                         input int a, input int fa, input string tag);
    e_ce = ce; e_oe = oe; e_drv = drv; e_vpp = vpp; e_vcc = vcc;
    e_busy = bsy; e_done = dn; e_fail = fl;
    e_addr = AW'(a); e_faddr = AW'(fa); e_tag = tag;
  endtask

  task automatic hold(input int n, input bit ce, oe, drv, vpp, vcc,
                      input int a, input string tag);
    set_exp(ce, oe, drv, vpp, vcc, 1, 0, 0, a, 0, tag);
    repeat (n) @(posedge clk);
  endtask

  task automatic end_state(input bit failed, input int a, input string tag);
    set_exp(1, 1, 0, 0, 0, 0, !failed, failed, a, failed ? a : 0, tag);
    repeat (5) @(posedge clk);
    check({tag, " end flags"}, {30'd0, done, fail}, failed ? 1 : 2);
    if (failed) check({tag, " fail address"}, int'(fail_addr), a);
  endtask

  task automatic run(input bit poke);
    bit failed;
    int k;
    for (int i = 0; i < N; i++) begin mem[i] = 8'hFF; pcnt[i] = 0; end
    @(negedge clk); start = 1;
    @(posedge clk); #1 start = 0;
    if (poke) fork
      begin
        // R11: start while busy must not disturb the trace
        repeat (30) @(negedge clk); start = 1;
        @(negedge clk); start = 0;
      end
    join_none
    hold(SETTLE, 1, 1, 0, 1, 1, 0, "R2");
    @(negedge clk);
    check("R11 flags cleared on start", {30'd0, done, fail}, 0);
    failed = 0;
    for (int a = 0; a < N && !failed; a++) begin
      if (a == 0) begin
        // first load cycle began at the settle edge; one cycle left of it
        set_exp(1, 1, 0, 1, 1, 1, 0, 0, a, 0, img[a] == 8'hFF ? "R6" : "R12");
        @(posedge clk);
      end else begin
        hold(1, 1, 1, 0, 1, 1, a, img[a] == 8'hFF ? "R6" : "R12");
      end
      if (img[a] == 8'hFF) continue;
      e_data = img[a];
      k = 0;
      forever begin
        hold(PULSE, 0, 1, 1, 1, 1, a, k == 0 ? "R3" : "R5");
        k++;
        hold(READ, 1, 0, 0, 1, 1, a, "R4");
        if (!bad[a] && k >= need[a]) break;
        if (k == MAXP) begin failed = 1; end_state(1, a, "R7"); break; end
      end
    end
    if (failed) return;
    hold(SETTLE, 1, 1, 0, 0, 0, 0, "R8");
    for (int a = 0; a < N; a++) begin
      hold(READ, 0, 0, 0, 0, 0, a, "R8");
      if (leaky[a]) begin end_state(1, a, "R9"); return; end
    end
    end_state(0, N - 1, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      img[i] = (i % 4 == 0) ? 8'hFF : 8'((i * 37) ^ 8'h5A) & 8'hFE;
      need[i] = 1 + i % 3;
      bad[i] = 0; leaky[i] = 0; mem[i] = 8'hFF; pcnt[i] = 0;
    end
    img[9] = 8'h3C;
    repeat (3) @(negedge clk);
    check("R1 reset busy/done/fail", {29'd0, busy, done, fail}, 0);
    check("R1 reset ce/oe/drive", {29'd0, ce_n, oe_n, dev_drive}, 6);
    check("R1 reset supplies", {30'd0, vpp_hi, vcc_hi}, 0);
    @(negedge clk); rst_n = 1;
    chk_on = 1;
    repeat (3) @(posedge clk);

    // mixed image, varied pulse counts, start poked mid-run
    run(1);
    // stuck byte at address 5
    bad[5] = 1;
    run(0);
    bad[5] = 0;
    // address 3 needs exactly the limit; address 9 loses a bit at nominal supply
    need[3] = MAXP;
    leaky[9] = 1;
    run(0);
    leaky[9] = 0;
    // erased image: no pulses at all
    for (int i = 0; i < N; i++) img[i] = 8'hFF;
    run(0);
    check("R6 no pulses on erased image", pcnt[0] + pcnt[7] + pcnt[15], 0);

    chk_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule